// File: doc/BRIEF.md
# Two-Channel Prescaled PWM Controller

This block generates up to two pulse-width-modulated outputs from one system clock. Each channel first slows the clock with a prescaler chosen from a fixed ratio set, then counts ticks of that slowed clock through a programmable period. During the opening part of each period, whose length is set by the duty value, it drives its active level. Software programs the block through a small synchronous register port. One shared control word holds a field per channel, and each channel also has its own word that packs the period and the duty.

A new period/duty word does not disturb a waveform that is running. It is held in a staging register and moves into the working counters only when the current period ends. A per-channel ready flag tells software when that transfer has happened. A channel can also be switched into a one-shot mode in which a self-clearing trigger bit produces exactly one period.

Top module: `pwm_dual_ctrl`

## Requirements
- R1: Word addresses are byte offsets. The control word is at 0x0 and channel n's period/duty word is at 0x4+4*n. Channel n's control field starts at bit 15*n, and only its bits [8:0] are stored; bits [14:9] of a field read as 0. Unmapped or misaligned addresses read as 0, and writes to them are ignored.
- R2: Prescaler codes 0..4 divide the clock by 120, 180, 240, 360 and 480. Codes 8..12 divide by 12000, 24000, 36000, 48000 and 72000. Code 15 divides by 1 when the bypass parameter is set.
- R3: Codes 5, 6, 7, 13 and 14 are invalid, and so is code 15 when bypass is disabled. A channel with an invalid code holds its inactive level.
- R4: Bits [31:16] of the period/duty word give the period length minus one, in prescaled ticks. Bits [15:0] give the duty in ticks. In each period the output is active for the first duty ticks and inactive for the rest.
- R5: A duty of 0 gives a constant inactive output. A duty greater than the period-minus-one field gives a constant active output.
- R6: A channel drives PWM only when both its enable bit (field bit 4) and its clock-gate bit (field bit 6) are 1. Otherwise it holds its inactive level.
- R7: When the active-state bit (field bit 5) is 1 the active level is 1. When it is 0 the active level is 0. The inactive level is always the opposite of the active level.
- R8: The read-only ready bit of channel n is at control bit 28+n. It reads 0 from the clock edge that captures a write to the channel's period/duty word. It reads 1 again after the staged value has been loaded. That load happens at the end of the current period, or on the next clock edge if the channel is idle. Reading a period/duty word returns the staged value.
- R9: While a channel's clock-gate bit is 0, its prescaler and period counters are held at zero. When the bit is set again, the waveform restarts from the start of a period.
- R10: When the one-shot bit (field bit 7) is 1, the channel runs only while the trigger bit (field bit 8) is 1. The trigger bit clears itself on the clock edge that ends one period.
- R11: After reset every control field and every period/duty word is 0, all ready bits are 1, and every output is 1. This is because active-state 0 makes the inactive level 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the prescaler source |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, captured on the rising edge |
| addr | input | ADDR_W | Byte address of the word to access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
A control write changes a channel's output from the first sample after the edge that captures it, and that first sample is tick 0 of the period. Each prescaled tick advances the phase by one, so the phase at sample i is floor(i/divisor) modulo the period. The ready bit falls on the edge that captures a period/duty write. It rises on the edge that closes the running period, or on the very next edge if the channel is idle. The one-shot trigger clears on that same closing edge. The bench drives every input and samples every output on the falling edge, counting samples from the write edge, so each expected value is taken in exactly the cycle worked out above.

// File: rtl/pwm_dual_pkg.sv
// Package: shared constants and the prescaler ratio decode for the
// two-channel PWM controller. Assumes 16-bit period and duty fields.
package pwm_dual_pkg;
    localparam int FLD_STRIDE = 15;   // control field spacing per channel
    localparam int FLD_W      = 9;    // stored bits per control field
    localparam int RDY_BASE   = 28;   // ready flag of channel 0
    localparam int CNT_W      = 16;   // period and duty width
    localparam int DIV_W      = 17;   // wide enough for the largest ratio
    localparam int B_EN       = 4;
    localparam int B_ACT      = 5;
    localparam int B_GATE     = 6;
    localparam int B_MODE     = 7;
    localparam int B_PULSE    = 8;

    // Maps a prescaler code to its divisor; 0 marks an invalid code.
    function automatic logic [DIV_W-1:0] code_to_div(input logic [3:0] code,
                                                     input logic bypass_ok);
        logic [DIV_W-1:0] d;
        case (code)
            4'd0:    d = 17'd120;
            4'd1:    d = 17'd180;
            4'd2:    d = 17'd240;
            4'd3:    d = 17'd360;
            4'd4:    d = 17'd480;
            4'd8:    d = 17'd12000;
            4'd9:    d = 17'd24000;
            4'd10:   d = 17'd36000;
            4'd11:   d = 17'd48000;
            4'd12:   d = 17'd72000;
            4'd15:   d = bypass_ok ? 17'd1 : 17'd0;
            default: d = 17'd0;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/pwm_prescaler.sv
// Module: pwm_prescaler
// Emits a one-cycle tick every div clocks while run is high. The count is
// held at zero while run is low, so every restart begins a fresh tick.
// Assumes div is nonzero whenever run is high.
module pwm_prescaler #(
    parameter int DIV_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             at_end;

    assign at_end = (cnt_q == div - 1'b1);
    assign tick   = run & at_end;

    // Cycle counter: wraps at the divisor, cleared while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_period_core.sv
// Module: pwm_period_core
// Counts prescaled ticks through one period and decides the active window.
// It loads the staged period/duty pair at the closing tick of a period, or
// at once while stopped. Assumes tick is only high while run is high.
module pwm_period_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             stage_pend,
    input  logic [CNT_W-1:0] stage_prd,
    input  logic [CNT_W-1:0] stage_duty,
    output logic             load,
    output logic             boundary,
    output logic             active,
    output logic [CNT_W-1:0] prd_cur,
    output logic [CNT_W-1:0] duty_cur,
    output logic [CNT_W-1:0] pcnt
);
    logic [CNT_W-1:0] pcnt_q, prd_q, duty_q;

    assign boundary = tick & (pcnt_q == prd_q);
    assign load     = stage_pend & (boundary | ~run);
    assign active   = run & (pcnt_q < duty_q);
    assign prd_cur  = prd_q;
    assign duty_cur = duty_q;
    assign pcnt     = pcnt_q;

    // Working period/duty pair: takes the staged pair on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd_q  <= '0;
            duty_q <= '0;
        end else if (load) begin
            prd_q  <= stage_prd;
            duty_q <= stage_duty;
        end
    end

    // Phase counter: advances per tick, restarts at period end or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (!run || boundary) begin
            pcnt_q <= '0;
        end else if (tick) begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_chan.sv
// Module: pwm_chan
// One PWM channel: decodes its control field, holds the staged
// period/duty word and its pending flag, and drives the output level.
// Assumes the control field layout of pwm_dual_pkg.
module pwm_chan
    import pwm_dual_pkg::*;
#(
    parameter bit BYPASS_OK = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FLD_W-1:0] fld,
    input  logic             pd_wr,
    input  logic [31:0]      pd_wdata,
    output logic             pwm_out,
    output logic             ready,
    output logic [31:0]      staged,
    output logic             pulse_done,
    output logic             run,
    output logic [CNT_W-1:0] prd_cur,
    output logic [CNT_W-1:0] duty_cur,
    output logic [CNT_W-1:0] pcnt
);
    logic [DIV_W-1:0] div;
    logic             valid, tick, load, boundary, active, pend_q;
    logic [31:0]      staged_q;

    assign div        = code_to_div(fld[3:0], BYPASS_OK);
    assign valid      = |div;
    assign run        = fld[B_GATE] & fld[B_EN] & valid
                      & (~fld[B_MODE] | fld[B_PULSE]);
    assign pulse_done = fld[B_MODE] & boundary;
    assign pwm_out    = active ? fld[B_ACT] : ~fld[B_ACT];
    assign ready      = ~pend_q;
    assign staged     = staged_q;

    // Staging word and pending flag: a write wins over a same-cycle load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_q <= '0;
            pend_q   <= 1'b0;
        end else if (pd_wr) begin
            staged_q <= pd_wdata;
            pend_q   <= 1'b1;
        end else if (load) begin
            pend_q   <= 1'b0;
        end
    end

    pwm_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (div),
        .tick  (tick)
    );

    pwm_period_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .tick       (tick),
        .stage_pend (pend_q),
        .stage_prd  (staged_q[31:16]),
        .stage_duty (staged_q[15:0]),
        .load       (load),
        .boundary   (boundary),
        .active     (active),
        .prd_cur    (prd_cur),
        .duty_cur   (duty_cur),
        .pcnt       (pcnt)
    );
endmodule

// File: rtl/pwm_dual_ctrl.sv
// Module: pwm_dual_ctrl
// Register-mapped PWM controller with NCH (1 or 2) channels sharing one
// control word. Holds the control fields, decodes writes, muxes reads and
// instantiates one pwm_chan per channel. Assumes word-aligned accesses,
// with the read data valid combinationally from addr.
module pwm_dual_ctrl #(
    parameter int NCH       = 2,
    parameter bit BYPASS_OK = 1'b1,
    parameter int ADDR_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NCH-1:0]    pwm_out
);
    import pwm_dual_pkg::*;

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]            word_idx;
    logic                        aligned, ctrl_wr;
    logic [NCH-1:0][FLD_W-1:0]   fld_q;
    logic [NCH-1:0]              pd_wr, ready_v, run_v, pulse_done_v;
    logic [NCH-1:0][31:0]        staged_v;
    logic [NCH-1:0][CNT_W-1:0]   prd_cur_v, duty_cur_v, pcnt_v;
    logic [31:0]                 ctrl_img;

    assign word_idx = addr[ADDR_W-1:2];
    assign aligned  = (addr[1:0] == 2'b00);
    assign ctrl_wr  = wr_en & aligned & (word_idx == '0);

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        assign pd_wr[n] = wr_en & aligned & (word_idx == IDX_W'(n + 1));

        // Control field: software write, else self-clear of the trigger bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fld_q[n] <= '0;
            end else if (ctrl_wr) begin
                fld_q[n] <= wdata[n*FLD_STRIDE +: FLD_W];
            end else if (pulse_done_v[n]) begin
                fld_q[n][B_PULSE] <= 1'b0;
            end
        end

        pwm_chan #(.BYPASS_OK(BYPASS_OK)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .fld        (fld_q[n]),
            .pd_wr      (pd_wr[n]),
            .pd_wdata   (wdata),
            .pwm_out    (pwm_out[n]),
            .ready      (ready_v[n]),
            .staged     (staged_v[n]),
            .pulse_done (pulse_done_v[n]),
            .run        (run_v[n]),
            .prd_cur    (prd_cur_v[n]),
            .duty_cur   (duty_cur_v[n]),
            .pcnt       (pcnt_v[n])
        );
    end

    // Control word image: stored fields plus ready flags.
    always_comb begin
        ctrl_img = '0;
        for (int n = 0; n < NCH; n++) begin
            ctrl_img[n*FLD_STRIDE +: FLD_W] = fld_q[n];
            ctrl_img[RDY_BASE + n]          = ready_v[n];
        end
    end

    // Read mux: control image, staged words, zero elsewhere.
    always_comb begin
        rdata = '0;
        if (aligned) begin
            if (word_idx == '0) begin
                rdata = ctrl_img;
            end
            for (int n = 0; n < NCH; n++) begin
                if (word_idx == IDX_W'(n + 1)) begin
                    rdata = staged_v[n];
                end
            end
        end
    end
endmodule

// File: rtl/pwm_dual_checker.sv
// Module: pwm_dual_checker
// Temporal checks on the PWM controller, bound into pwm_dual_ctrl.
// Assumes the same parameters and package constants as the design.
module pwm_dual_checker
    import pwm_dual_pkg::*;
#(
    parameter int NCH       = 2,
    parameter bit BYPASS_OK = 1'b1,
    parameter int ADDR_W    = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [ADDR_W-1:0]         addr,
    input logic [NCH-1:0][FLD_W-1:0] fld_q,
    input logic [NCH-1:0]            pwm_out,
    input logic [NCH-1:0]            ready_v,
    input logic [NCH-1:0]            run_v,
    input logic [NCH-1:0]            pulse_done_v,
    input logic [NCH-1:0][CNT_W-1:0] prd_cur_v,
    input logic [NCH-1:0][CNT_W-1:0] duty_cur_v,
    input logic [NCH-1:0][CNT_W-1:0] pcnt_v
);
    logic ctrl_hit;
    assign ctrl_hit = wr_en && (addr == '0);

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        logic       bad_code, idle_lvl;
        logic [3:0] code;
        assign code     = fld_q[n][3:0];
        assign bad_code = (code inside {4'd5, 4'd6, 4'd7, 4'd13, 4'd14})
                        || (code == 4'd15 && !BYPASS_OK);
        assign idle_lvl = ~fld_q[n][B_ACT];

        assert_no_enable_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !(fld_q[n][B_EN] && fld_q[n][B_GATE]) |-> pwm_out[n] == idle_lvl);

        assert_bad_code_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
            bad_code |-> pwm_out[n] == idle_lvl);

        assert_zero_duty_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
            duty_cur_v[n] == '0 |-> pwm_out[n] == idle_lvl);

        assert_full_duty_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (run_v[n] && duty_cur_v[n] > prd_cur_v[n]) |-> pwm_out[n] == fld_q[n][B_ACT]);

        assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(4 * (n + 1))) |=> !ready_v[n]);

        assert_gate_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !fld_q[n][B_GATE] |=> pcnt_v[n] == '0);

        assert_trigger_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (pulse_done_v[n] && !ctrl_hit) |=> !fld_q[n][B_PULSE]);
    end
endmodule

bind pwm_dual_ctrl pwm_dual_checker #(
    .NCH(NCH), .BYPASS_OK(BYPASS_OK), .ADDR_W(ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .fld_q        (fld_q),
    .pwm_out      (pwm_out),
    .ready_v      (ready_v),
    .run_v        (run_v),
    .pulse_done_v (pulse_done_v),
    .prd_cur_v    (prd_cur_v),
    .duty_cur_v   (duty_cur_v),
    .pcnt_v       (pcnt_v)
);

// File: tb/tb_pwm_dual_ctrl.sv
`timescale 1ns/1ps
// Bench: table of waveform vectors walked by one loop, then directed tests
// for reset, register map, staging/ready, gating, one-shot mode.
module tb_pwm_dual_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  pwm_out;
    int          n_chk = 0;
    int          n_bad = 0;

    localparam logic [8:0] F_EN = 9'h010, F_ACT = 9'h020, F_GATE = 9'h040,
                           F_MODE = 9'h080, F_PULSE = 9'h100;

    // {req[59:56], code[55:52], pad[51:50], ch[49], act[48], prd-1[47:32], duty[31:16], samples[15:0]}
    localparam int NV = 12;
    localparam logic [59:0] VECS [NV] = '{
        {4'd4,  4'd15, 2'b00, 1'b0, 1'b1, 16'd3, 16'd1, 16'd12},    // R4
        {4'd1,  4'd15, 2'b00, 1'b1, 1'b1, 16'd4, 16'd3, 16'd15},    // R1 channel 1 field
        {4'd7,  4'd15, 2'b00, 1'b0, 1'b0, 16'd3, 16'd1, 16'd12},    // R7 inverted
        {4'd5,  4'd15, 2'b00, 1'b0, 1'b1, 16'd2, 16'd0, 16'd9},     // R5 zero duty
        {4'd5,  4'd15, 2'b00, 1'b1, 1'b1, 16'd2, 16'd5, 16'd9},     // R5 full duty
        {4'd5,  4'd15, 2'b00, 1'b0, 1'b1, 16'd0, 16'd1, 16'd6},     // R5 one-tick period
        {4'd3,  4'd5,  2'b00, 1'b0, 1'b1, 16'd3, 16'd1, 16'd8},     // R3
        {4'd3,  4'd13, 2'b00, 1'b1, 1'b1, 16'd3, 16'd1, 16'd8},     // R3
        {4'd3,  4'd7,  2'b00, 1'b0, 1'b0, 16'd3, 16'd1, 16'd8},     // R3 inverted idle
        {4'd2,  4'd0,  2'b00, 1'b0, 1'b1, 16'd1, 16'd1, 16'd500},   // R2 divide 120
        {4'd2,  4'd4,  2'b00, 1'b1, 1'b1, 16'd2, 16'd1, 16'd1500},  // R2 divide 480
        {4'd2,  4'd8,  2'b00, 1'b0, 1'b1, 16'd1, 16'd1, 16'd24200}  // R2 divide 12000
    };

    pwm_dual_ctrl dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .pwm_out (pwm_out)
    );

    always #2.5 clk = ~clk;

    function automatic int bench_div(input logic [3:0] c);
        case (c)
            4'd0: return 120;    4'd1: return 180;    4'd2: return 240;
            4'd3: return 360;    4'd4: return 480;    4'd8: return 12000;
            4'd9: return 24000;  4'd10: return 36000; 4'd11: return 48000;
            4'd12: return 72000; 4'd15: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic exp_level(input logic [3:0] c, input logic act,
                                       input int prd_m1, input int duty, input int i);
        int d;
        d = bench_div(c);
        if (d == 0) return ~act;
        return (((i / d) % (prd_m1 + 1)) < duty) ? act : ~act;
    endfunction

    function automatic logic [31:0] cf(input int ch, input logic [8:0] f);
        return 32'(f) << (15 * ch);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // Write: called at a falling edge, returns at the falling edge after capture.
    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        // R11: reset state
        rd_reg(4'h0, r);  check("R11", r, 32'h3000_0000);
        rd_reg(4'h4, r);  check("R11", r, 32'h0);
        rd_reg(4'h8, r);  check("R11", r, 32'h0);
        check("R11", {30'd0, pwm_out}, 32'd3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: field layout, staged readback, unmapped and misaligned reads
        wr_reg(4'h0, 32'hFFF7_FFEF);
        rd_reg(4'h0, r);  check("R1", r, 32'h30F7_81EF);
        wr_reg(4'h8, 32'h0005_0002);
        rd_reg(4'h8, r);  check("R1", r, 32'h0005_0002);
        rd_reg(4'hC, r);  check("R1", r, 32'h0);
        rd_reg(4'h2, r);  check("R1", r, 32'h0);
        wr_reg(4'h0, 32'h0);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            logic [3:0] c;
            int ch, prd, duty, ns;
            logic act;
            string tag;
            tag  = $sformatf("R%0d", VECS[v][59:56]);
            c    = VECS[v][55:52];
            ch   = int'(VECS[v][49]);
            act  = VECS[v][48];
            prd  = int'(VECS[v][47:32]);
            duty = int'(VECS[v][31:16]);
            ns   = int'(VECS[v][15:0]);
            wr_reg(4'h0, 32'h0);
            wr_reg(4'(4 * (ch + 1)), {16'(prd), 16'(duty)});
            @(negedge clk); @(negedge clk);
            wr_reg(4'h0, cf(ch, {5'(act) << 1 | 5'h1, 4'h0} | F_GATE | 9'(c)));
            for (int i = 0; i < ns; i++) begin
                check(tag, {31'd0, pwm_out[ch]}, {31'd0, exp_level(c, act, prd, duty, i)});
                @(negedge clk);
            end
        end

        // R8: idle channel loads on the next edge
        wr_reg(4'h0, 32'h0);
        wr_reg(4'h4, {16'd3, 16'd1});
        rd_reg(4'h0, r);  check("R8", {31'd0, r[28]}, 32'd0);
        @(negedge clk);
        rd_reg(4'h0, r);  check("R8", {31'd0, r[28]}, 32'd1);

        // R8: running channel keeps old values until its period ends
        wr_reg(4'h0, cf(0, F_ACT | F_GATE | F_EN | 9'hF));
        check("R8", {31'd0, pwm_out[0]}, 32'd1);
        wr_reg(4'h4, {16'd2, 16'd2});
        for (int i = 1; i < 10; i++) begin
            logic e;
            e = (i < 4) ? ((i % 4) < 1) : (((i - 4) % 3) < 2);
            check("R8", {31'd0, pwm_out[0]}, {31'd0, e});
            rd_reg(4'h0, r);
            if (i == 1 || i == 3) check("R8", {31'd0, r[28]}, 32'd0);
            if (i == 4) check("R8", {31'd0, r[28]}, 32'd1);
            @(negedge clk);
        end

        // R6: enable without gate, gate without enable
        wr_reg(4'h0, cf(0, F_ACT | F_EN | 9'hF));
        for (int i = 0; i < 4; i++) begin
            check("R6", {31'd0, pwm_out[0]}, 32'd0);
            @(negedge clk);
        end
        wr_reg(4'h0, cf(0, F_ACT | F_GATE | 9'hF));
        for (int i = 0; i < 4; i++) begin
            check("R6", {31'd0, pwm_out[0]}, 32'd0);
            @(negedge clk);
        end

        // R9: gate off mid-period, then restart from phase zero
        wr_reg(4'h0, cf(0, F_ACT | F_GATE | F_EN | 9'hF));
        @(negedge clk);
        wr_reg(4'h0, cf(0, F_ACT | F_EN | 9'hF));
        for (int i = 0; i < 3; i++) begin
            check("R9", {31'd0, pwm_out[0]}, 32'd0);
            @(negedge clk);
        end
        wr_reg(4'h0, cf(0, F_ACT | F_GATE | F_EN | 9'hF));
        for (int i = 0; i < 6; i++) begin
            check("R9", {31'd0, pwm_out[0]}, {31'd0, logic'((i % 3) < 2)});
            @(negedge clk);
        end

        // R10: one-shot emits a single period and clears its trigger
        wr_reg(4'h0, 32'h0);
        wr_reg(4'h4, {16'd2, 16'd1});
        @(negedge clk); @(negedge clk);
        wr_reg(4'h0, cf(0, F_MODE | F_PULSE | F_ACT | F_GATE | F_EN | 9'hF));
        for (int i = 0; i < 7; i++) begin
            check("R10", {31'd0, pwm_out[0]}, {31'd0, logic'(i == 0)});
            @(negedge clk);
        end
        rd_reg(4'h0, r);  check("R10", r, 32'h3000_00FF);
        wr_reg(4'h0, cf(0, F_MODE | F_PULSE | F_ACT | F_GATE | F_EN | 9'hF));
        check("R10", {31'd0, pwm_out[0]}, 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule